// File: doc/BRIEF.md
# Mesh Best-Cost Broadcast Switch

This switch sits at one node of a mesh of tour-search processing elements. Its job is to spread the lowest tour cost found anywhere in the array. Every cycle it samples five input ports: the local processing element, and the north, east, south and west neighbours. Each port carries a path cost, a vertex list and a 2-bit transmission code. No port is addressed. One registered output buffer drives all four neighbours and the local element at the same time.

A decision stage qualifies each input by its code. It picks the cheapest qualified input and compares that input with a stored best-so-far cost. A candidate that improves on the stored cost is forwarded. The stored cost is updated at the same time, so a value that returns over the mesh is never sent again. When the winner came from the local element, the output is marked as a fresh local result. When the winner came from a neighbour, the output is marked as a relayed result that the local element must also adopt. Every decision reaches the output register one clock later.

Top module: `bestcost_mesh_switch`

## Requirements
- R1: While reset is asserted, the output code is 2'b00, the output cost is all ones and the output vertex list is zero. The stored best cost returns to all ones, so a cost forwarded before the reset can be forwarded again after it.
- R2: The transmission codes are 2'b00 (idle, nothing sent), 2'b01 (quiet, candidate dropped), 2'b10 (fresh result from the local element) and 2'b11 (relayed result from another element). An input whose code is 2'b00 or 2'b01 is ignored, whatever its cost. It changes neither the output nor the stored best cost.
- R3: Among the inputs with code 2'b10 or 2'b11, the one with the lowest cost wins. Its cost and vertex list appear on the output one clock after they are sampled.
- R4: When valid inputs tie on cost, the winner follows the fixed priority local, north, east, south, west.
- R5: A forwarded winner from the local port carries code 2'b10, whatever code it arrived with. A forwarded winner from any neighbour carries code 2'b11.
- R6: A winner is forwarded only when its cost is strictly below the stored best cost. Otherwise the output code for that cycle is 2'b01.
- R7: When no input is valid, the output code is 2'b00.
- R8: In a cycle that forwards nothing, the output cost and vertex list keep their previous values.
- R9: Forwarding a value sets the stored best cost to that value. The same cost arriving again is therefore dropped with code 2'b01.
- R10: A cost of all ones means no tour. It is never forwarded, even when the stored best is also all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pe_code | input | 2 | Transmission code from the local element |
| pe_cost | input | COST_W | Path cost from the local element |
| pe_vlist | input | VLIST_W | Vertex list from the local element |
| north_code | input | 2 | Transmission code from the north neighbour |
| north_cost | input | COST_W | Path cost from the north neighbour |
| north_vlist | input | VLIST_W | Vertex list from the north neighbour |
| east_code | input | 2 | Transmission code from the east neighbour |
| east_cost | input | COST_W | Path cost from the east neighbour |
| east_vlist | input | VLIST_W | Vertex list from the east neighbour |
| south_code | input | 2 | Transmission code from the south neighbour |
| south_cost | input | COST_W | Path cost from the south neighbour |
| south_vlist | input | VLIST_W | Vertex list from the south neighbour |
| west_code | input | 2 | Transmission code from the west neighbour |
| west_cost | input | COST_W | Path cost from the west neighbour |
| west_vlist | input | VLIST_W | Vertex list from the west neighbour |
| out_code | output | 2 | Broadcast transmission code |
| out_cost | output | COST_W | Broadcast path cost |
| out_vlist | output | VLIST_W | Broadcast vertex list |

## Verification
Every result of this switch, whether forwarded, quiet or idle, is due exactly one rising edge after its inputs are sampled. No input takes a longer path. The bench applies each input set on a falling edge and lets one rising edge pass. It then compares all three outputs at the next falling edge, before the next input set is applied. Dropped and ignored inputs are checked in the same slot, by confirming that the code shows the drop and that cost and vertex list still hold the earlier winner. The stored best cost is observed only through later inputs that are or are not forwarded.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Transmission codes; bit 1 set means the flit carries a candidate cost
    typedef enum logic [1:0] {
        CODE_IDLE  = 2'b00,
        CODE_QUIET = 2'b01,
        CODE_FRESH = 2'b10,
        CODE_RELAY = 2'b11
    } tx_code_e;

    // Port order doubles as tie priority: lower index wins
    localparam int NUM_PORTS  = 5;
    localparam int PORT_LOCAL = 0;
    localparam int PORT_NORTH = 1;
    localparam int PORT_EAST  = 2;
    localparam int PORT_SOUTH = 3;
    localparam int PORT_WEST  = 4;

    function automatic logic code_is_candidate(input logic [1:0] code);
        return (code == CODE_FRESH) || (code == CODE_RELAY);
    endfunction

endpackage

// File: rtl/bcs_port_qualify.sv
module bcs_port_qualify #(
    parameter int N_PORTS = 5
) (
    input  logic [N_PORTS-1:0][1:0] code,
    output logic [N_PORTS-1:0]      valid
);
    import bcs_pkg::*;

    // One decoder per port; quiet and idle flits never compete
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign valid[p] = code_is_candidate(code[p]);
    end

endmodule

// File: rtl/bcs_min_select.sv
module bcs_min_select #(
    parameter int N_PORTS = 5,
    parameter int COST_W  = 8,
    localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic [N_PORTS-1:0]             valid,
    input  logic [N_PORTS-1:0][COST_W-1:0] cost,
    output logic                           found,
    output logic [IDX_W-1:0]               win_idx,
    output logic [COST_W-1:0]              win_cost
);
    // Linear chain: a later port only displaces the running winner when
    // strictly cheaper, which gives lower indices the tie.
    logic [N_PORTS:0]             fnd_c;
    logic [N_PORTS:0][COST_W-1:0] cost_c;
    logic [N_PORTS:0][IDX_W-1:0]  idx_c;

    assign fnd_c[0]  = 1'b0;
    assign cost_c[0] = '1;
    assign idx_c[0]  = '0;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_stage
        logic take;
        assign take        = valid[p] && (!fnd_c[p] || (cost[p] < cost_c[p]));
        assign fnd_c[p+1]  = fnd_c[p] | valid[p];
        assign cost_c[p+1] = take ? cost[p] : cost_c[p];
        assign idx_c[p+1]  = take ? IDX_W'(p) : idx_c[p];
    end

    assign found    = fnd_c[N_PORTS];
    assign win_idx  = idx_c[N_PORTS];
    assign win_cost = cost_c[N_PORTS];

endmodule

// File: rtl/bestcost_mesh_switch.sv
module bestcost_mesh_switch #(
    parameter int COST_W  = 8,
    parameter int VLIST_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pe_code,
    input  logic [COST_W-1:0]  pe_cost,
    input  logic [VLIST_W-1:0] pe_vlist,
    input  logic [1:0]         north_code,
    input  logic [COST_W-1:0]  north_cost,
    input  logic [VLIST_W-1:0] north_vlist,
    input  logic [1:0]         east_code,
    input  logic [COST_W-1:0]  east_cost,
    input  logic [VLIST_W-1:0] east_vlist,
    input  logic [1:0]         south_code,
    input  logic [COST_W-1:0]  south_cost,
    input  logic [VLIST_W-1:0] south_vlist,
    input  logic [1:0]         west_code,
    input  logic [COST_W-1:0]  west_cost,
    input  logic [VLIST_W-1:0] west_vlist,
    output logic [1:0]         out_code,
    output logic [COST_W-1:0]  out_cost,
    output logic [VLIST_W-1:0] out_vlist
);
    import bcs_pkg::*;

    localparam int NP    = NUM_PORTS;
    localparam int IDX_W = $clog2(NP);

    typedef struct packed {
        logic [COST_W-1:0]  best;
        logic [1:0]         code;
        logic [COST_W-1:0]  cost;
        logic [VLIST_W-1:0] vlist;
    } sw_state_t;

    // Gather ports into arrays in priority order
    logic [NP-1:0][1:0]         code_a;
    logic [NP-1:0][COST_W-1:0]  cost_a;
    logic [NP-1:0][VLIST_W-1:0] vlist_a;

    assign code_a[PORT_LOCAL]  = pe_code;
    assign code_a[PORT_NORTH]  = north_code;
    assign code_a[PORT_EAST]   = east_code;
    assign code_a[PORT_SOUTH]  = south_code;
    assign code_a[PORT_WEST]   = west_code;
    assign cost_a[PORT_LOCAL]  = pe_cost;
    assign cost_a[PORT_NORTH]  = north_cost;
    assign cost_a[PORT_EAST]   = east_cost;
    assign cost_a[PORT_SOUTH]  = south_cost;
    assign cost_a[PORT_WEST]   = west_cost;
    assign vlist_a[PORT_LOCAL] = pe_vlist;
    assign vlist_a[PORT_NORTH] = north_vlist;
    assign vlist_a[PORT_EAST]  = east_vlist;
    assign vlist_a[PORT_SOUTH] = south_vlist;
    assign vlist_a[PORT_WEST]  = west_vlist;

    logic [NP-1:0]     valid;
    logic              found;
    logic [IDX_W-1:0]  win_idx;
    logic [COST_W-1:0] win_cost;

    bcs_port_qualify #(.N_PORTS(NP)) u_qual (
        .code  (code_a),
        .valid (valid)
    );

    bcs_min_select #(.N_PORTS(NP), .COST_W(COST_W)) u_min (
        .valid    (valid),
        .cost     (cost_a),
        .found    (found),
        .win_idx  (win_idx),
        .win_cost (win_cost)
    );

    sw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (found && (win_cost < st_q.best)) begin
            st_d.best  = win_cost;
            st_d.cost  = win_cost;
            st_d.vlist = vlist_a[win_idx];
            st_d.code  = (win_idx == IDX_W'(PORT_LOCAL)) ? CODE_FRESH : CODE_RELAY;
        end else if (found) begin
            st_d.code  = CODE_QUIET;
        end else begin
            st_d.code  = CODE_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.best  <= '1;
            st_q.code  <= CODE_IDLE;
            st_q.cost  <= '1;
            st_q.vlist <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [COST_W-1:0] best_q;
    assign best_q    = st_q.best;
    assign out_code  = st_q.code;
    assign out_cost  = st_q.cost;
    assign out_vlist = st_q.vlist;

endmodule

// File: rtl/bcs_switch_chk.sv
module bcs_switch_chk #(
    parameter int COST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pe_code,
    input logic [COST_W-1:0] pe_cost,
    input logic [1:0]        north_code,
    input logic [1:0]        east_code,
    input logic [1:0]        south_code,
    input logic [1:0]        west_code,
    input logic [1:0]        out_code,
    input logic [COST_W-1:0] out_cost,
    input logic [COST_W-1:0] best
);
    import bcs_pkg::*;

    logic any_nb, any_in;
    assign any_nb = north_code[1] | east_code[1] | south_code[1] | west_code[1];
    assign any_in = any_nb | pe_code[1];

    AST_FRESH_FROM_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code == CODE_FRESH) |-> ($past(pe_code[1]) && (out_cost == $past(pe_cost)))); // R5

    AST_RELAY_FROM_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code == CODE_RELAY) |-> $past(any_nb)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_in) |-> ((out_code == CODE_IDLE) && $stable(out_cost))); // R7

    AST_STRICT_IMPROVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_code[1] |-> (out_cost < $past(best))); // R6

    AST_BEST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        best <= $past(best)); // R9

    AST_NO_INFINITY_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_code[1] |-> (out_cost != '1)); // R10

endmodule

bind bestcost_mesh_switch bcs_switch_chk #(.COST_W(COST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pe_code    (pe_code),
    .pe_cost    (pe_cost),
    .north_code (north_code),
    .east_code  (east_code),
    .south_code (south_code),
    .west_code  (west_code),
    .out_code   (out_code),
    .out_cost   (out_cost),
    .best       (best_q)
);

// File: tb/bestcost_mesh_switch_tb.sv
module bestcost_mesh_switch_tb;

    typedef struct packed {
        logic [1:0]  c;
        logic [7:0]  k;
        logic [15:0] v;
    } port_t;

    typedef struct packed {
        logic [7:0] req;
        port_t l, n, e, s, w, x;
    } vec_t;

    localparam port_t Z = '{2'b00, 8'h00, 16'h0000};

    // req: requirement number exercised; x: expected output one edge later
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'd7,  Z, Z, Z, Z, Z, '{2'b00, 8'hFF, 16'h0000}},                                  // R7 R8
        '{8'd5,  '{2'b10, 8'h40, 16'h1111}, Z, Z, Z, Z, '{2'b10, 8'h40, 16'h1111}},          // R5
        '{8'd3,  Z, '{2'b11, 8'h30, 16'h2222}, '{2'b11, 8'h35, 16'h3333}, Z, Z,
                 '{2'b11, 8'h30, 16'h2222}},                                                  // R3
        '{8'd9,  Z, '{2'b11, 8'h30, 16'h2222}, Z, Z, Z, '{2'b01, 8'h30, 16'h2222}},          // R9
        '{8'd6,  '{2'b10, 8'h50, 16'h1111}, Z, Z, Z, Z, '{2'b01, 8'h30, 16'h2222}},          // R6
        '{8'd2,  Z, Z, Z, '{2'b00, 8'h01, 16'h4444}, '{2'b01, 8'h05, 16'h5555},
                 '{2'b00, 8'h30, 16'h2222}},                                                  // R2
        '{8'd4,  Z, Z, '{2'b11, 8'h20, 16'h3333}, '{2'b11, 8'h20, 16'h4444},
                 '{2'b11, 8'h20, 16'h5555}, '{2'b11, 8'h20, 16'h3333}},                       // R4
        '{8'd4,  '{2'b10, 8'h10, 16'h1111}, '{2'b11, 8'h10, 16'h2222}, Z, Z, Z,
                 '{2'b10, 8'h10, 16'h1111}},                                                  // R4
        '{8'd3,  '{2'b10, 8'h0F, 16'h1111}, '{2'b11, 8'h0E, 16'h2222}, '{2'b11, 8'h0D, 16'h3333},
                 '{2'b11, 8'h03, 16'h4444}, '{2'b11, 8'h09, 16'h5555},
                 '{2'b11, 8'h03, 16'h4444}},                                                  // R3
        '{8'd5,  '{2'b11, 8'h02, 16'h1111}, Z, Z, Z, Z, '{2'b10, 8'h02, 16'h1111}},          // R5
        '{8'd8,  Z, Z, Z, Z, Z, '{2'b00, 8'h02, 16'h1111}}                                   // R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    port_t il, in_n, ie, is_, iw;
    logic [1:0]  out_code;
    logic [7:0]  out_cost;
    logic [15:0] out_vlist;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bestcost_mesh_switch #(.COST_W(8), .VLIST_W(16)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pe_code     (il.c),   .pe_cost     (il.k),   .pe_vlist    (il.v),
        .north_code  (in_n.c), .north_cost  (in_n.k), .north_vlist (in_n.v),
        .east_code   (ie.c),   .east_cost   (ie.k),   .east_vlist  (ie.v),
        .south_code  (is_.c),  .south_cost  (is_.k),  .south_vlist (is_.v),
        .west_code   (iw.c),   .west_cost   (iw.k),   .west_vlist  (iw.v),
        .out_code    (out_code),
        .out_cost    (out_cost),
        .out_vlist   (out_vlist)
    );

    task automatic check(input string tag, input port_t x);
        checks++;
        if (out_code !== x.c || out_cost !== x.k || out_vlist !== x.v) begin
            fails++;
            $display("FAIL %s: actual code=%b cost=%h vlist=%h expected code=%b cost=%h vlist=%h",
                     tag, out_code, out_cost, out_vlist, x.c, x.k, x.v);
        end
    endtask

    // Apply on a falling edge, let one rising edge register, check on next falling edge
    task automatic step(input port_t l, input port_t n, input port_t e, input port_t s,
                        input port_t w, input string tag, input port_t x);
        il = l; in_n = n; ie = e; is_ = s; iw = w;
        @(posedge clk);
        @(negedge clk);
        check(tag, x);
    endtask

    task automatic do_reset();
        il = Z; in_n = Z; ie = Z; is_ = Z; iw = Z;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        do_reset();
        check("R1 reset state", '{2'b00, 8'hFF, 16'h0000});
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].l, VECS[i].n, VECS[i].e, VECS[i].s, VECS[i].w,
                 $sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].x);
        end
        do_reset();
        check("R1 reset mid-run", '{2'b00, 8'hFF, 16'h0000});
        step(Z, '{2'b11, 8'hFF, 16'h2222}, Z, Z, Z, "R10 infinity dropped",
             '{2'b01, 8'hFF, 16'h0000});
        step(Z, '{2'b11, 8'hFE, 16'h2222}, Z, Z, Z, "R10 just below infinity",
             '{2'b11, 8'hFE, 16'h2222});
        step('{2'b10, 8'h40, 16'h1111}, Z, Z, Z, Z, "R1 best cleared by reset",
             '{2'b10, 8'h40, 16'h1111});
        step(Z, Z, Z, Z, '{2'b11, 8'h00, 16'h5555}, "R3 zero cost from west",
             '{2'b11, 8'h00, 16'h5555});
        step(Z, Z, Z, Z, '{2'b11, 8'h00, 16'h5555}, "R9 zero repeated",
             '{2'b01, 8'h00, 16'h5555});
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule